// File: doc/BRIEF.md
# Transmit/Receive Lane Configuration Register Bank

This block holds the per-lane control settings for a group of serial ports, each with four lanes. For every lane it drives three codes: a transmit output-level code, a transmit pre-emphasis code and a receive polarity-swap flag. Settings are written and read through a simple byte-wide register interface. Each port has lane-level registers and one port-wide register. A write to the port-wide register copies its level and pre-emphasis values into all four lane fields of that port.

A pin-control input overrides the register values at the outputs. While it is high, every lane drives the default output level, and pre-emphasis follows a single strap pin. The registers still accept writes and return reads in this mode. Their values reach the outputs once pin control is released. A small data stage inverts each lane's bit according to its swap flag. A parameter selects whether that stage is registered or combinational.

Top module: `txrx_lane_cfg`

## Requirements
- R1: After reset, every lane level code is 2'b10, every pre-emphasis code is 0 and every swap flag is 0. The port-wide register reads 0x02 and each lane level register reads 0xAA.
- R2: Level codes are 00=±200 mV, 01=±300 mV, 10=±400 mV and 11=±600 mV. The lane level register is at offset 2, with lane n in bits [2n+1:2n]. A write there sets the lane level outputs and reads back unchanged.
- R3: Pre-emphasis is a 3-bit code per lane, where 0 means no boost. Offset 3 holds lane 0 in bits [2:0] and lane 1 in bits [6:4]. Offset 4 holds lane 2 and lane 3 in the same positions. Bits 3 and 7 read as zero.
- R4: A pre-emphasis code of 7 is stored and driven as 6. This applies to both lane and port-wide writes.
- R5: The port-wide register is at offset 1, with the level in bits [1:0] and pre-emphasis in bits [4:2]. Bits [7:5] read as zero. A write to it sets all four lane level and pre-emphasis fields of the port, and the lane registers then read back those copied values.
- R6: A lane register write made after a port-wide write changes only the addressed lane fields. The port-wide register keeps its stored value.
- R7: While pin_mode is 1, every lane level output is 2'b10. Every pre-emphasis output is 0 when pe_pin is 0, or 3 when pe_pin is 1. Register writes still take effect and become visible at the outputs once pin_mode returns to 0.
- R8: The swap flags are at offset 0, bits [3:0], with one bit per lane. Bits [7:4] read as zero and ignore writes.
- R9: lane_dout equals lane_din XOR swap_out. In the default registered variant it appears one clock later and uses the swap value held at that clock edge.
- R10: Address bits [5:4] select the port and bits [3:0] select the offset. Any upper address bit set, a port index at or above NPORTS, or an unused offset makes a write have no effect and a read return 0.
- R11: The swap flags and the data stage are unaffected by pin_mode.
- R12: Flat outputs place lane g = port*4+lane at lvl_out[2g+1:2g], pe_out[3g+2:3g] and swap_out[g].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W | Register address |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Combinational read data for cfg_addr |
| pin_mode | input | 1 | Pin-control mode, forces strapped defaults |
| pe_pin | input | 1 | Pre-emphasis strap used in pin-control mode |
| lane_din | input | 4*NPORTS | Receive lane bits before polarity swap |
| lane_dout | output | 4*NPORTS | Lane bits after polarity swap |
| lvl_out | output | 8*NPORTS | Per-lane output level codes |
| pe_out | output | 12*NPORTS | Per-lane pre-emphasis codes |
| swap_out | output | 4*NPORTS | Per-lane polarity-swap flags |

## Verification
Two pairs of functions can act in the same cycle. In the first pair, a swap-flag write and a lane bit enter the data stage together. The bench changes lane_din and writes the swap register in one cycle, then expects the first result to use the old flags and the following result to use the new flags. In the second pair, a port-wide write arrives while pin control is active. The bench expects the outputs to stay forced while the register read returns the new value, and expects the copied lane values to appear once pin control drops.

// File: rtl/lanecfg_pkg.sv
package lanecfg_pkg;
   localparam int LANES = 4;
   localparam int LVL_W = 2;
   localparam int PE_W  = 3;
   localparam int DW    = 8;

   localparam logic [LVL_W-1:0] LVL_DEF = 2'b10;
   localparam logic [PE_W-1:0]  PE_TOP  = 3'd6;

   typedef enum logic [3:0] {
      OFF_SWAP = 4'd0,
      OFF_PORT = 4'd1,
      OFF_LVL  = 4'd2,
      OFF_PEL  = 4'd3,
      OFF_PEH  = 4'd4
   } cfg_off_e;

   function automatic logic [PE_W-1:0] pe_clamp(input logic [PE_W-1:0] c);
      return (c > PE_TOP) ? PE_TOP : c;
   endfunction
endpackage

// File: rtl/lanecfg_port.sv
module lanecfg_port
   import lanecfg_pkg::*;
(
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic [3:0]             off,
   input  logic [DW-1:0]          wdata,
   output logic [DW-1:0]          rdata,
   output logic [LANES*LVL_W-1:0] lvl_q,
   output logic [LANES*PE_W-1:0]  pe_q,
   output logic [LANES-1:0]       swap_q
);
   logic [LVL_W+PE_W-1:0] port_q;
   logic [PE_W-1:0]       bc_pe;

   assign bc_pe = pe_clamp(wdata[4:2]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q  <= {LANES{LVL_DEF}};
         pe_q   <= '0;
         swap_q <= '0;
         port_q <= {3'd0, LVL_DEF};
      end else if (wr_en) begin
         case (off)
            OFF_SWAP: swap_q <= wdata[LANES-1:0];
            OFF_PORT: begin
               port_q <= {bc_pe, wdata[1:0]};
               for (int l = 0; l < LANES; l++) begin
                  lvl_q[l*LVL_W +: LVL_W] <= wdata[1:0];
                  pe_q[l*PE_W +: PE_W]    <= bc_pe;
               end
            end
            OFF_LVL: lvl_q <= wdata;
            OFF_PEL: begin
               pe_q[2:0] <= pe_clamp(wdata[2:0]);
               pe_q[5:3] <= pe_clamp(wdata[6:4]);
            end
            OFF_PEH: begin
               pe_q[8:6]  <= pe_clamp(wdata[2:0]);
               pe_q[11:9] <= pe_clamp(wdata[6:4]);
            end
            default: ;
         endcase
      end
   end

   always_comb begin
      case (off)
         OFF_SWAP: rdata = {4'd0, swap_q};
         OFF_PORT: rdata = {3'd0, port_q};
         OFF_LVL:  rdata = lvl_q;
         OFF_PEL:  rdata = {1'b0, pe_q[5:3], 1'b0, pe_q[2:0]};
         OFF_PEH:  rdata = {1'b0, pe_q[11:9], 1'b0, pe_q[8:6]};
         default:  rdata = '0;
      endcase
   end

   // R5
   port_bcast_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && off == OFF_PORT) |=> (lvl_q == {LANES{$past(wdata[1:0])}}));

   // R4
   pe_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pe_q[2:0] != 3'd7) && (pe_q[5:3] != 3'd7) &&
      (pe_q[8:6] != 3'd7) && (pe_q[11:9] != 3'd7));

   // R8
   swap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && off == OFF_SWAP) |=> $stable(swap_q));
endmodule

// File: rtl/lanecfg_outsel.sv
module lanecfg_outsel
   import lanecfg_pkg::*;
#(
   parameter int NL     = 12,
   parameter int PIN_PE = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               pin_mode,
   input  logic               pe_pin,
   input  logic [NL*LVL_W-1:0] reg_lvl,
   input  logic [NL*PE_W-1:0]  reg_pe,
   output logic [NL*LVL_W-1:0] lvl_out,
   output logic [NL*PE_W-1:0]  pe_out
);
   localparam logic [PE_W-1:0] PIN_CODE = PE_W'(PIN_PE);
   logic [PE_W-1:0] pin_pe_code;

   assign pin_pe_code = pe_pin ? PIN_CODE : '0;

   for (genvar g = 0; g < NL; g++) begin : g_lane
      assign lvl_out[g*LVL_W +: LVL_W] = pin_mode ? LVL_DEF : reg_lvl[g*LVL_W +: LVL_W];
      assign pe_out[g*PE_W +: PE_W]    = pin_mode ? pin_pe_code : reg_pe[g*PE_W +: PE_W];
   end

   // R7
   pin_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pin_mode |-> (lvl_out == {NL{LVL_DEF}}));

   // R7
   reg_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pin_mode |-> (pe_out == reg_pe && lvl_out == reg_lvl));
endmodule

// File: rtl/lanecfg_swapdp.sv
module lanecfg_swapdp #(
   parameter int NL        = 12,
   parameter bit REGISTERED = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NL-1:0] din,
   input  logic [NL-1:0] swap,
   output logic [NL-1:0] dout
);
   if (REGISTERED) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) dout <= '0;
         else        dout <= din ^ swap;
      end
      // R9
      swap_dp_chk: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> (dout == ($past(din) ^ $past(swap))));
   end else begin : g_comb
      assign dout = din ^ swap;
   end
endmodule

// File: rtl/txrx_lane_cfg.sv
module txrx_lane_cfg
   import lanecfg_pkg::*;
#(
   parameter int NPORTS     = 3,
   parameter int ADDR_W     = 8,
   parameter int PIN_PE     = 3,
   parameter bit DP_REG     = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          cfg_we,
   input  logic [ADDR_W-1:0]             cfg_addr,
   input  logic [DW-1:0]                 cfg_wdata,
   output logic [DW-1:0]                 cfg_rdata,
   input  logic                          pin_mode,
   input  logic                          pe_pin,
   input  logic [NPORTS*LANES-1:0]       lane_din,
   output logic [NPORTS*LANES-1:0]       lane_dout,
   output logic [NPORTS*LANES*LVL_W-1:0] lvl_out,
   output logic [NPORTS*LANES*PE_W-1:0]  pe_out,
   output logic [NPORTS*LANES-1:0]       swap_out
);
   localparam int NL = NPORTS * LANES;

   if (NPORTS < 1 || NPORTS > 4) begin : g_bad_ports
      $error("NPORTS must be 1 to 4");
   end
   if (ADDR_W < 7) begin : g_bad_addr
      $error("ADDR_W must be at least 7");
   end
   if (PIN_PE < 0 || PIN_PE > 6) begin : g_bad_pe
      $error("PIN_PE must be a legal pre-emphasis code");
   end

   logic [1:0]             port_sel;
   logic [3:0]             off;
   logic                   addr_ok;
   logic [DW-1:0]          prd [NPORTS];
   logic [NL*LVL_W-1:0]    reg_lvl;
   logic [NL*PE_W-1:0]     reg_pe;

   assign port_sel = cfg_addr[5:4];
   assign off      = cfg_addr[3:0];
   assign addr_ok  = (cfg_addr[ADDR_W-1:6] == '0) && (int'(port_sel) < NPORTS);

   for (genvar p = 0; p < NPORTS; p++) begin : g_port
      logic wr_p;
      assign wr_p = cfg_we && addr_ok && (int'(port_sel) == p);
      lanecfg_port u_port (
         .clk    (clk),
         .rst_n  (rst_n),
         .wr_en  (wr_p),
         .off    (off),
         .wdata  (cfg_wdata),
         .rdata  (prd[p]),
         .lvl_q  (reg_lvl[p*LANES*LVL_W +: LANES*LVL_W]),
         .pe_q   (reg_pe[p*LANES*PE_W +: LANES*PE_W]),
         .swap_q (swap_out[p*LANES +: LANES])
      );
   end

   always_comb begin
      cfg_rdata = '0;
      for (int p = 0; p < NPORTS; p++) begin
         if (addr_ok && int'(port_sel) == p) cfg_rdata = prd[p];
      end
   end

   lanecfg_outsel #(.NL(NL), .PIN_PE(PIN_PE)) u_outsel (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin_mode (pin_mode),
      .pe_pin   (pe_pin),
      .reg_lvl  (reg_lvl),
      .reg_pe   (reg_pe),
      .lvl_out  (lvl_out),
      .pe_out   (pe_out)
   );

   lanecfg_swapdp #(.NL(NL), .REGISTERED(DP_REG)) u_swapdp (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (lane_din),
      .swap  (swap_out),
      .dout  (lane_dout)
   );

   // R10
   bad_addr_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !addr_ok |-> (cfg_rdata == '0));

   // R11
   swap_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_mode && !cfg_we) |=> $stable(swap_out));
endmodule

// File: tb/tb_txrx_lane_cfg.sv
`timescale 1ns/1ps
module tb_txrx_lane_cfg;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [7:0]  cfg_addr = '0;
   logic [7:0]  cfg_wdata = '0;
   logic [7:0]  cfg_rdata;
   logic        pin_mode = 1'b0;
   logic        pe_pin = 1'b0;
   logic [11:0] lane_din = '0;
   logic [11:0] lane_dout;
   logic [23:0] lvl_out;
   logic [35:0] pe_out;
   logic [11:0] swap_out;

   int nvec = 0;
   int nbad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   txrx_lane_cfg dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .pin_mode(pin_mode),
      .pe_pin(pe_pin), .lane_din(lane_din), .lane_dout(lane_dout),
      .lvl_out(lvl_out), .pe_out(pe_out), .swap_out(swap_out)
   );

   // {write, addr, data, expected readback}
   localparam int NV = 15;
   localparam logic [24:0] VEC [NV] = '{
      {1'b1, 8'h02, 8'hE4, 8'hE4},   // R2
      {1'b1, 8'h03, 8'hFF, 8'h66},   // R3 R4
      {1'b1, 8'h14, 8'h25, 8'h25},   // R3
      {1'b1, 8'h20, 8'hFA, 8'h0A},   // R8
      {1'b1, 8'h11, 8'h1D, 8'h19},   // R5 R4
      {1'b0, 8'h12, 8'h00, 8'h55},   // R5
      {1'b0, 8'h13, 8'h00, 8'h66},   // R5
      {1'b0, 8'h14, 8'h00, 8'h66},   // R5
      {1'b1, 8'h35, 8'h55, 8'h00},   // R10
      {1'b1, 8'h05, 8'h77, 8'h00},   // R10
      {1'b1, 8'hC2, 8'h00, 8'h00},   // R10
      {1'b0, 8'h02, 8'h00, 8'hE4},   // R10
      {1'b1, 8'h12, 8'hC5, 8'hC5},   // R6
      {1'b0, 8'h11, 8'h00, 8'h19},   // R6
      {1'b0, 8'h13, 8'h00, 8'h66}    // R6
   };

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      nvec++;
      if (act !== exp) begin
         nbad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] d);
      @(negedge clk);
      cfg_addr = a;
      #1 d = cfg_rdata;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 20);
      nvec++; nbad++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      logic [7:0] r;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // reset state R1
      @(negedge clk);
      chk("R1 lvl", 64'(lvl_out), 64'hAAAAAA);
      chk("R1 pe", 64'(pe_out), 64'h0);
      chk("R1 swap", 64'(swap_out), 64'h0);
      rd(8'h01, r); chk("R1 port reg", 64'(r), 64'h02);
      rd(8'h02, r); chk("R1 lane lvl reg", 64'(r), 64'hAA);

      for (int i = 0; i < NV; i++) begin
         if (VEC[i][24]) wr(VEC[i][23:16], VEC[i][15:8]);
         rd(VEC[i][23:16], r);
         chk($sformatf("vector %0d (R2-R10 table)", i), 64'(r), 64'(VEC[i][7:0]));
      end

      // R12 R2 R6 flat output layout
      chk("R12 lvl layout", 64'(lvl_out), 64'hAAC5E4);
      chk("R12 pe layout R3", 64'(pe_out), 64'h000DB6036);
      chk("R8 swap out", 64'(swap_out), 64'hA00);

      // R9 data stage
      @(negedge clk); lane_din = 12'hFFF;
      @(negedge clk); chk("R9 swap xor", 64'(lane_dout), 64'h5FF);

      // R9 same-cycle swap write and data
      @(negedge clk);
      lane_din = 12'h000; cfg_we = 1'b1; cfg_addr = 8'h20; cfg_wdata = 8'h05;
      @(negedge clk);
      cfg_we = 1'b0;
      chk("R9 old flags used", 64'(lane_dout), 64'hA00);
      @(negedge clk);
      chk("R9 new flags used", 64'(lane_dout), 64'h500);

      // R7 pin-control mode
      @(negedge clk); pin_mode = 1'b1; pe_pin = 1'b0;
      #1;
      chk("R7 pin lvl", 64'(lvl_out), 64'hAAAAAA);
      chk("R7 pin pe 0", 64'(pe_out), 64'h0);
      @(negedge clk); pe_pin = 1'b1;
      #1;
      chk("R7 pin pe 3", 64'(pe_out), 64'h6DB6DB6DB);
      chk("R11 swap in pin mode", 64'(swap_out), 64'h500);
      wr(8'h01, 8'h0F);
      #1;
      chk("R7 still forced", 64'(lvl_out), 64'hAAAAAA);
      rd(8'h01, r); chk("R7 write taken", 64'(r), 64'h0F);
      lane_din = 12'h0F0;
      @(negedge clk);
      chk("R11 data stage in pin mode", 64'(lane_dout), 64'h5F0);
      pin_mode = 1'b0;
      #1;
      chk("R7 released lvl", 64'(lvl_out[7:0]), 64'hFF);
      chk("R7 released pe", 64'(pe_out[11:0]), 64'h6DB);

      finish_run();
   end
endmodule